// File: doc/BRIEF.md
# Trap Return Controller

This block resolves what happens when a return-from-exception instruction retires. From the current program counter, the live status bits (supervisor, previous supervisor, exception enable), the debug-mode flag, the instruction's one-bit debug selector and the two saved contexts (normal and debug), it picks the next program counter and the new status bits. It also raises a request to drop debug mode, an illegal-instruction request and a halt request.

The decision is made combinationally in the cycle where `valid_i` is high. The resulting PC, status and requests are captured together at the following clock edge. The priority order is fixed:

1. A clear supervisor bit.
2. A set exception-enable bit.
3. A normal-mode return.
4. A debug-mode return.
5. A fall-through that only advances the PC.

Instructions are 4 bytes long and the PC is 32 bits wide by default.

Top module: `trap_return_unit`

## Requirements
- R1: With `valid_i` high and `sup_i` = 0, `next_pc_o` becomes `pc_i`+4 and `sup_o`/`exc_en_o` copy `sup_i`/`exc_en_i`. `halt_o` is 1 exactly when `exc_en_i` = 0. `illegal_o` and `clr_dbg_o` are 0.
- R2: With `valid_i` high, `sup_i` = 1 and `exc_en_i` = 1, `illegal_o` = 1, `halt_o` = 1, `next_pc_o` = `pc_i`+4, the status bits are unchanged and `clr_dbg_o` = 0.
- R3: With `valid_i` high, `sup_i` = 1, `exc_en_i` = 0, `dbg_mode_i` = 0 and `dbg_sel_i` = 0, `next_pc_o` = `norm_pc_i`, `exc_en_o` = 1 and `sup_o` = `prev_sup_i`. No request is raised.
- R4: With `valid_i` high, `sup_i` = 1, `exc_en_i` = 0, `dbg_mode_i` = 1 and `dbg_sel_i` = 1, `next_pc_o` = `dbg_pc_i`, `exc_en_o` = `dbg_exc_en_i`, `sup_o` = `dbg_sup_i` and `clr_dbg_o` = 1. `clr_dbg_o` is never 1 unless debug mode was set for that instruction.
- R5: With `sup_i` = 1 and `exc_en_i` = 0, a mismatch between `dbg_mode_i` and `dbg_sel_i` gives `pc_i`+4, unchanged status and no request.
- R6: The supervisor and enable checks take priority over both return paths. A saved context is never loaded while `sup_i` = 0 or `exc_en_i` = 1.
- R7: The results appear at the first rising clock edge after the valid cycle, with PC and status changing in the same edge. Before that edge the outputs keep their old values.
- R8: In a cycle with `valid_i` low, `next_pc_o`, `sup_o` and `exc_en_o` hold. `illegal_o`, `halt_o` and `clr_dbg_o` are 0 after the next edge.
- R9: While `rst_ni` is low: `next_pc_o` = 0, `sup_o` = 1, `exc_en_o` = 0, and all three requests are 0.
- R10: The PC increment wraps modulo 2^32, so `pc_i` = 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A return instruction executes this cycle |
| pc_i | input | 32 | PC of the return instruction |
| sup_i | input | 1 | Current supervisor bit |
| prev_sup_i | input | 1 | Previous supervisor bit |
| exc_en_i | input | 1 | Current exception-enable bit |
| norm_pc_i | input | 32 | Saved PC for a normal-mode return |
| dbg_pc_i | input | 32 | Saved PC for a debug-mode return |
| dbg_sup_i | input | 1 | Saved supervisor bit of the debug context |
| dbg_exc_en_i | input | 1 | Saved enable bit of the debug context |
| dbg_mode_i | input | 1 | Core is in debug mode |
| dbg_sel_i | input | 1 | Debug selector field of the instruction |
| next_pc_o | output | 32 | Registered next PC |
| sup_o | output | 1 | Registered new supervisor bit |
| exc_en_o | output | 1 | Registered new exception-enable bit |
| clr_dbg_o | output | 1 | Leave debug mode (one cycle) |
| illegal_o | output | 1 | Illegal-instruction request (one cycle) |
| halt_o | output | 1 | Halt request (one cycle) |

## Verification
A wrong priority decision shows at the ports one edge after the valid cycle. It appears as a saved PC where PC+4 was due, or as a missing or extra request, because every path leaves a distinct mark on `next_pc_o` or the request lines. A status register that is stale or loaded from the wrong context shows in `sup_o`/`exc_en_o` on that same edge. Because these registers hold across idle cycles, the error stays visible until the next return instruction. Corrupted hold logic appears one edge after an idle cycle, as a PC that moves or a request that stays set.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;
  typedef enum logic [2:0] {
    PATH_USER    = 3'd0,
    PATH_ILLEGAL = 3'd1,
    PATH_NORMAL  = 3'd2,
    PATH_DEBUG   = 3'd3,
    PATH_NOP     = 3'd4
  } ret_path_e;

  typedef struct packed {
    logic sup;
    logic exc_en;
  } stat_t;

  typedef struct packed {
    logic clr_dbg;
    logic illegal;
    logic halt;
  } req_t;
endpackage

// File: rtl/trap_ret_decide.sv
module trap_ret_decide
  import trap_ret_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [PC_W-1:0] pc_i,
  input  stat_t           cur_i,
  input  logic            prev_sup_i,
  input  logic [PC_W-1:0] norm_pc_i,
  input  logic [PC_W-1:0] dbg_pc_i,
  input  stat_t           dbg_stat_i,
  input  logic            dbg_mode_i,
  input  logic            dbg_sel_i,
  output ret_path_e       path_o,
  output logic [PC_W-1:0] pc_o,
  output stat_t           stat_o,
  output req_t            req_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [PC_W-1:0] seq_pc;
  assign seq_pc = pc_i + STEP;

  // fixed priority: supervisor, enable, normal return, debug return
  always_comb begin
    if (!cur_i.sup)                          path_o = PATH_USER;
    else if (cur_i.exc_en)                   path_o = PATH_ILLEGAL;
    else if (!dbg_mode_i && !dbg_sel_i)      path_o = PATH_NORMAL;
    else if (dbg_mode_i && dbg_sel_i)        path_o = PATH_DEBUG;
    else                                     path_o = PATH_NOP;
  end

  always_comb begin
    pc_o   = seq_pc;
    stat_o = cur_i;
    req_o  = '0;
    unique case (path_o)
      PATH_USER:    req_o.halt = ~cur_i.exc_en;
      PATH_ILLEGAL: begin
        req_o.illegal = 1'b1;
        req_o.halt    = 1'b1;
      end
      PATH_NORMAL: begin
        pc_o          = norm_pc_i;
        stat_o.exc_en = 1'b1;
        stat_o.sup    = prev_sup_i;
      end
      PATH_DEBUG: begin
        pc_o          = dbg_pc_i;
        stat_o        = dbg_stat_i;
        req_o.clr_dbg = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_ret_regs.sv
module trap_ret_regs
  import trap_ret_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PC_W-1:0] pc_d_i,
  input  stat_t           stat_d_i,
  input  req_t            req_d_i,
  output logic [PC_W-1:0] pc_q_o,
  output stat_t           stat_q_o,
  output req_t            req_q_o
);
  localparam stat_t STAT_RST = '{sup: 1'b1, exc_en: 1'b0};

  // PC and status share one enable so they move together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q_o   <= RESET_PC;
      stat_q_o <= STAT_RST;
    end else if (load_i) begin
      pc_q_o   <= pc_d_i;
      stat_q_o <= stat_d_i;
    end
  end

  // requests are single-cycle pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q_o <= '0;
    else         req_q_o <= load_i ? req_d_i : '0;
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_ret_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            sup_i,
  input  logic            prev_sup_i,
  input  logic            exc_en_i,
  input  logic [PC_W-1:0] norm_pc_i,
  input  logic [PC_W-1:0] dbg_pc_i,
  input  logic            dbg_sup_i,
  input  logic            dbg_exc_en_i,
  input  logic            dbg_mode_i,
  input  logic            dbg_sel_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            sup_o,
  output logic            exc_en_o,
  output logic            clr_dbg_o,
  output logic            illegal_o,
  output logic            halt_o
);
  ret_path_e       path;
  logic [PC_W-1:0] pc_d;
  stat_t           stat_d, stat_q, cur, dbg_stat;
  req_t            req_d, req_q;

  assign cur      = '{sup: sup_i, exc_en: exc_en_i};
  assign dbg_stat = '{sup: dbg_sup_i, exc_en: dbg_exc_en_i};

  trap_ret_decide #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_decide (
    .pc_i       (pc_i),
    .cur_i      (cur),
    .prev_sup_i (prev_sup_i),
    .norm_pc_i  (norm_pc_i),
    .dbg_pc_i   (dbg_pc_i),
    .dbg_stat_i (dbg_stat),
    .dbg_mode_i (dbg_mode_i),
    .dbg_sel_i  (dbg_sel_i),
    .path_o     (path),
    .pc_o       (pc_d),
    .stat_o     (stat_d),
    .req_o      (req_d)
  );

  trap_ret_regs #(.PC_W(PC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (valid_i),
    .pc_d_i   (pc_d),
    .stat_d_i (stat_d),
    .req_d_i  (req_d),
    .pc_q_o   (next_pc_o),
    .stat_q_o (stat_q),
    .req_q_o  (req_q)
  );

  assign sup_o     = stat_q.sup;
  assign exc_en_o  = stat_q.exc_en;
  assign clr_dbg_o = req_q.clr_dbg;
  assign illegal_o = req_q.illegal;
  assign halt_o    = req_q.halt;
endmodule

// File: rtl/trap_return_unit_chk.sv
module trap_return_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [PC_W-1:0] pc_i,
  input logic            sup_i,
  input logic            prev_sup_i,
  input logic            exc_en_i,
  input logic [PC_W-1:0] norm_pc_i,
  input logic [PC_W-1:0] dbg_pc_i,
  input logic            dbg_sup_i,
  input logic            dbg_exc_en_i,
  input logic            dbg_mode_i,
  input logic            dbg_sel_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            sup_o,
  input logic            exc_en_o,
  input logic            clr_dbg_o,
  input logic            illegal_o,
  input logic            halt_o
);
  localparam logic [PC_W-1:0] FOUR = PC_W'(4);

  p_user_path_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !sup_i |=> next_pc_o == $past(pc_i) + FOUR
      && halt_o == !$past(exc_en_i) && !illegal_o && !clr_dbg_o);

  p_illegal_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sup_i && exc_en_i |=> illegal_o && halt_o && sup_o && exc_en_o
      && next_pc_o == $past(pc_i) + FOUR);

  p_normal_ret_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sup_i && !exc_en_i && !dbg_mode_i && !dbg_sel_i
      |=> next_pc_o == $past(norm_pc_i) && exc_en_o && sup_o == $past(prev_sup_i));

  p_debug_ret_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sup_i && !exc_en_i && dbg_mode_i && dbg_sel_i
      |=> next_pc_o == $past(dbg_pc_i) && clr_dbg_o
        && sup_o == $past(dbg_sup_i) && exc_en_o == $past(dbg_exc_en_i));

  p_clr_needs_dbg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dbg_o |-> $past(dbg_mode_i) && $past(valid_i));

  p_mismatch_nop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sup_i && !exc_en_i && (dbg_mode_i != dbg_sel_i)
      |=> $countones({clr_dbg_o, illegal_o, halt_o}) == 0 && sup_o && !exc_en_o);

  p_illegal_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !clr_dbg_o && halt_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o) && $stable(sup_o) && $stable(exc_en_o)
      && !illegal_o && !halt_o && !clr_dbg_o);
endmodule

bind trap_return_unit trap_return_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .pc_i         (pc_i),
  .sup_i        (sup_i),
  .prev_sup_i   (prev_sup_i),
  .exc_en_i     (exc_en_i),
  .norm_pc_i    (norm_pc_i),
  .dbg_pc_i     (dbg_pc_i),
  .dbg_sup_i    (dbg_sup_i),
  .dbg_exc_en_i (dbg_exc_en_i),
  .dbg_mode_i   (dbg_mode_i),
  .dbg_sel_i    (dbg_sel_i),
  .next_pc_o    (next_pc_o),
  .sup_o        (sup_o),
  .exc_en_o     (exc_en_o),
  .clr_dbg_o    (clr_dbg_o),
  .illegal_o    (illegal_o),
  .halt_o       (halt_o)
);

// File: tb/trap_return_unit_tb.sv
module trap_return_unit_tb;
  typedef struct packed {
    logic [3:0]  req;
    logic        sup, psup, en, dbg, sel, dsup, den;
    logic [31:0] pc, npc, dpc;
    logic [31:0] epc;
    logic        esup, een, eill, ehalt, eclr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    // R1: user mode, enable set
    '{4'd1, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h100, 32'h1111_0000, 32'h2222_0000, 32'h104, 1'b0,1'b1,1'b0,1'b0,1'b0},
    // R1: user mode, enable clear -> halt
    '{4'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h200, 32'h1111_0000, 32'h2222_0000, 32'h204, 1'b0,1'b0,1'b0,1'b1,1'b0},
    // R2: supervisor with enable set
    '{4'd2, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h300, 32'h1111_0000, 32'h2222_0000, 32'h304, 1'b1,1'b1,1'b1,1'b1,1'b0},
    // R3: normal return, prev sup 0
    '{4'd3, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 32'h400, 32'h0000_4000, 32'h2222_0000, 32'h4000, 1'b0,1'b1,1'b0,1'b0,1'b0},
    // R3: normal return, prev sup 1
    '{4'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h480, 32'h0000_5550, 32'h2222_0000, 32'h5550, 1'b1,1'b1,1'b0,1'b0,1'b0},
    // R4: debug return, saved sup 0 en 1
    '{4'd4, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 32'h500, 32'h1111_0000, 32'h0000_8000, 32'h8000, 1'b0,1'b1,1'b0,1'b0,1'b1},
    // R4: debug return, saved sup 1 en 0
    '{4'd4, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 32'h580, 32'h1111_0000, 32'h0000_9004, 32'h9004, 1'b1,1'b0,1'b0,1'b0,1'b1},
    // R5: normal mode, selector 1
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 32'h700, 32'h1111_0000, 32'h2222_0000, 32'h704, 1'b1,1'b0,1'b0,1'b0,1'b0},
    // R5: debug mode, selector 0
    '{4'd5, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 32'h800, 32'h1111_0000, 32'h2222_0000, 32'h804, 1'b1,1'b0,1'b0,1'b0,1'b0},
    // R6: user mode beats debug return
    '{4'd6, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 32'h900, 32'h1111_0000, 32'h0000_A000, 32'h904, 1'b0,1'b1,1'b0,1'b0,1'b0},
    // R6: enable check beats normal return
    '{4'd6, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'hA00, 32'h0000_B000, 32'h2222_0000, 32'hA04, 1'b1,1'b1,1'b1,1'b1,1'b0},
    // R10: increment wraps
    '{4'd10, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'hFFFF_FFFC, 32'h1111_0000, 32'h2222_0000, 32'h0, 1'b0,1'b1,1'b0,1'b0,1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, norm_pc_i = '0, dbg_pc_i = '0;
  logic        sup_i = 1'b0, prev_sup_i = 1'b0, exc_en_i = 1'b0;
  logic        dbg_sup_i = 1'b0, dbg_exc_en_i = 1'b0, dbg_mode_i = 1'b0, dbg_sel_i = 1'b0;
  logic [31:0] next_pc_o;
  logic        sup_o, exc_en_o, clr_dbg_o, illegal_o, halt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  trap_return_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pc_i(pc_i),
    .sup_i(sup_i), .prev_sup_i(prev_sup_i), .exc_en_i(exc_en_i),
    .norm_pc_i(norm_pc_i), .dbg_pc_i(dbg_pc_i), .dbg_sup_i(dbg_sup_i),
    .dbg_exc_en_i(dbg_exc_en_i), .dbg_mode_i(dbg_mode_i), .dbg_sel_i(dbg_sel_i),
    .next_pc_o(next_pc_o), .sup_o(sup_o), .exc_en_o(exc_en_o),
    .clr_dbg_o(clr_dbg_o), .illegal_o(illegal_o), .halt_o(halt_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag, input vec_t v);
    chk(tag, "next_pc", next_pc_o, v.epc);
    chk(tag, "sup", 32'(sup_o), 32'(v.esup));
    chk(tag, "exc_en", 32'(exc_en_o), 32'(v.een));
    chk(tag, "illegal", 32'(illegal_o), 32'(v.eill));
    chk(tag, "halt", 32'(halt_o), 32'(v.ehalt));
    chk(tag, "clr_dbg", 32'(clr_dbg_o), 32'(v.eclr));
  endtask

  task automatic apply(input vec_t v);
    pc_i = v.pc; norm_pc_i = v.npc; dbg_pc_i = v.dpc;
    sup_i = v.sup; prev_sup_i = v.psup; exc_en_i = v.en;
    dbg_mode_i = v.dbg; dbg_sel_i = v.sel; dbg_sup_i = v.dsup; dbg_exc_en_i = v.den;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t idle;
    // R9: reset state
    #12;
    chk("R9", "next_pc", next_pc_o, 32'h0);
    chk("R9", "sup", 32'(sup_o), 32'h1);
    chk("R9", "exc_en", 32'(exc_en_o), 32'h0);
    chk("R9", "requests", {29'h0, clr_dbg_o, illegal_o, halt_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      apply(TBL[i]);
      valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
      check_outs($sformatf("R%0d[%0d]", TBL[i].req, i), TBL[i]);
    end

    // R8: idle cycle holds state, clears pulses (last vector left pc 0, sup 0, en 1)
    @(negedge clk_i);
    idle = TBL[NV-1];
    idle.eill = 1'b0; idle.ehalt = 1'b0; idle.eclr = 1'b0;
    sup_i = 1'b1; exc_en_i = 1'b1; pc_i = 32'h1234;
    @(negedge clk_i);
    check_outs("R8", idle);

    // R8: pulse from illegal path drops after one idle cycle
    apply(TBL[2]);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check_outs("R2", TBL[2]);
    @(negedge clk_i);
    idle = TBL[2];
    idle.eill = 1'b0; idle.ehalt = 1'b0;
    check_outs("R8", idle);

    // R7: outputs unchanged before the capturing edge, then PC and status together
    apply(TBL[3]);
    valid_i = 1'b1;
    #2;
    chk("R7", "pc before edge", next_pc_o, 32'h304);
    chk("R7", "exc_en before edge", 32'(exc_en_o), 32'h1);
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    chk("R7", "pc after edge", next_pc_o, 32'h4000);
    chk("R7", "sup after edge", 32'(sup_o), 32'h0);
    @(negedge clk_i);

    // R9: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    chk("R9", "next_pc async", next_pc_o, 32'h0);
    chk("R9", "sup async", 32'(sup_o), 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule